// File: doc/BRIEF.md
# Three-Wire Capable SPI Word Master

This block is an SPI master that moves one word per request. A transfer starts when `start` is pulsed while the engine is idle. The request carries the word to send, the clock polarity, the clock phase, the bit order, the word length (1 to 32 bits), the chip-select index and the chip-select polarity. The engine first parks SCK at the idle level for the chosen polarity. It then selects the target line, runs the data edges at a rate set by a programmable half-period divider and deselects the line. In the cycle the engine drops `busy`, it pulses `done` and presents the received word.

The block can also run half-duplex over a single data wire. In three-wire mode, receive data comes from the MOSI pad instead of MISO. For a receive word the master stops driving that pad, and it can first insert one turnaround SCK pulse that carries no data. A transmit-absent input keeps the MOSI driver off at all times. Receiving still works in that case by turning the shared line around.

Top module: `spiw_master`

## Requirements
- R1: Consecutive SCK edges within a transfer are exactly `cfg_half_div`+1 clock cycles apart, so a value of 0 gives one cycle per half-period. SCK changes only at those divider intervals while busy.
- R2: SCK rests at `cfg_cpol`. With `cfg_cpha`=0 the target samples on the leading edge (away from idle), and with `cfg_cpha`=1 it samples on the trailing edge. Each word takes exactly 2·length data edges.
- R3: The word length is `cfg_len_m1`+1, from 1 to 32 bits. MSB-first sends `tx_word[len-1]` first and LSB-first sends `tx_word[0]` first. Received bits are placed with the same ordering, and the bits of `rx_word` above the length read as zero.
- R4: At the clock edge that accepts a request, SCK moves to `cfg_cpol`. The selected chip-select line reaches its active level no sooner than one half-period later.
- R5: Line `cfg_cs_idx` is active at 0 by default, or at 1 when `cfg_cs_high` is set. Every other line stays at its inactive level. After a transfer a line rests at the inverse of the level it last used as active. No more than one line is ever at its active level.
- R6: After reset every chip-select line is 1, SCK is 0, `busy`, `done` and `rx_word` are 0, and MOSI is driven unless `cfg_tx_absent` is set.
- R7: In three-wire mode the received bits come from `mosi_i` and `miso` has no effect.
- R8: `mosi_oe` drops only for a three-wire receive word. It stays low from before the select until the end of that word. In four-wire mode MOSI stays driven even when `cfg_rx_dir` is set.
- R9: For a three-wire receive word with `cfg_turn_pulse` set, one extra SCK pulse (non-idle, then idle) is issued after the select and before the first data edge. Nothing is sampled on it, which gives 2·length+2 edges.
- R10: While `cfg_tx_absent` is 1, `mosi_oe` is 0 in every cycle. A three-wire receive still returns the target's word.
- R11: A `start` pulse while `busy` is 1 is ignored: the word in flight is unchanged and no second transfer follows.
- R12: `done` is high for exactly one cycle, `busy` falls in that same cycle, and `rx_word` holds the received word from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_cs_high | input | 1 | 1: selected line is active-high |
| cfg_three_wire | input | 1 | Half-duplex over the MOSI pad |
| cfg_turn_pulse | input | 1 | Turnaround SCK pulse before a three-wire receive |
| cfg_rx_dir | input | 1 | Word is a receive (releases the pad in three-wire mode) |
| cfg_tx_absent | input | 1 | No transmit line: never drive MOSI |
| cfg_len_m1 | input | LEN_W (5) | Word length minus one |
| cfg_half_div | input | DIV_W (8) | SCK half-period minus one, in clock cycles |
| cfg_cs_idx | input | IDX_W (2) | Chip-select line to use |
| tx_word | input | WORD_W (32) | Word to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | WORD_W (32) | Last received word |
| sck | output | 1 | Serial clock |
| mosi_o | output | 1 | Data out value |
| mosi_oe | output | 1 | Data out enable (0 = high impedance) |
| mosi_i | input | 1 | Value read back from the MOSI pad |
| miso | input | 1 | Data in for four-wire mode |
| cs_o | output | NUM_CS (4) | Chip-select lines |

## Verification
Most internal faults show up at SCK or at the chip-select lines within the word they affect. An edge counter that is off by one gives the wrong number of SCK edges before deselect. A divider fault changes the spacing between edges from the first data edge onward. A bad per-line polarity memory puts the wrong levels on `cs_o` at the next select or right after `done`. A stale direction flag appears on `mosi_oe` before the first data edge of a three-wire word. A wrong shift or bit-reversal path can only be seen as a bad `rx_word` in the `done` cycle, or as wrong bits at a behavioural target that records MOSI on its sampling edges.

// File: rtl/spiw_pkg.sv
`timescale 1ns/1ps
package spiw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PREP   = 3'd1,
        ST_ARM    = 3'd2,
        ST_LEAD   = 3'd3,
        ST_TURN_A = 3'd4,
        ST_TURN_B = 3'd5,
        ST_SHIFT  = 3'd6,
        ST_TAIL   = 3'd7
    } spiw_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb;
        logic cs_high;
        logic three;
        logic turn;
        logic rxdir;
    } spiw_mode_t;

endpackage

// File: rtl/spiw_tick_gen.sv
`timescale 1ns/1ps
module spiw_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == half_div);
        cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: the counter never runs past the programmed half-period
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= half_div));
endmodule

// File: rtl/spiw_cs_decode.sv
`timescale 1ns/1ps
module spiw_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = 2
) (
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              sel_on,
    input  logic [NUM_CS-1:0] pol,
    output logic [NUM_CS-1:0] cs
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign cs[g] = (sel_on && (sel_idx == IDX_W'(g))) ? pol[g] : ~pol[g];
    end
endmodule

// File: rtl/spiw_master.sv
`timescale 1ns/1ps
module spiw_master
    import spiw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 8,
    localparam int LEN_W  = $clog2(WORD_W),
    localparam int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int EDGE_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_cs_high,
    input  logic              cfg_three_wire,
    input  logic              cfg_turn_pulse,
    input  logic              cfg_rx_dir,
    input  logic              cfg_tx_absent,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [IDX_W-1:0]  cfg_cs_idx,
    input  logic [WORD_W-1:0] tx_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_o
);
    typedef struct packed {
        spiw_state_e       st;
        spiw_mode_t        m;
        logic [LEN_W-1:0]  len_m1;
        logic [DIV_W-1:0]  div;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [WORD_W-1:0] rx_word;
        logic [EDGE_W-1:0] edge_cnt;
        logic              sck;
        logic              sel;
        logic              hiz;
        logic              done;
        logic [NUM_CS-1:0] pol;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick;

    logic [WORD_W-1:0] tx_rev, tx_load, rx_rev, rx_fin, len_mask;
    logic              last_edge, sample_now, launch_now, din;

    spiw_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.st != ST_IDLE),
        .half_div (r_q.div),
        .tick     (tick)
    );

    spiw_cs_decode #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_cs (
        .sel_idx (r_q.idx),
        .sel_on  (r_q.sel),
        .pol     (r_q.pol),
        .cs      (cs_o)
    );

    // word alignment for both bit orders
    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            tx_rev[i] = tx_word[WORD_W-1-i];
            rx_rev[i] = r_q.rx_sh[WORD_W-1-i];
        end
        tx_load  = cfg_lsb_first ? tx_rev
                                 : (tx_word << ((WORD_W-1) - int'(cfg_len_m1)));
        len_mask = {WORD_W{1'b1}} >> ((WORD_W-1) - int'(r_q.len_m1));
        rx_fin   = r_q.m.lsb ? (rx_rev >> ((WORD_W-1) - int'(r_q.len_m1)))
                             : (r_q.rx_sh & len_mask);
    end

    // edge classification inside the data phase
    always_comb begin
        last_edge  = (r_q.edge_cnt == {r_q.len_m1, 1'b1});
        sample_now = r_q.m.cpha ? r_q.edge_cnt[0] : ~r_q.edge_cnt[0];
        launch_now = !sample_now && !(r_q.m.cpha && (r_q.edge_cnt == '0));
        din        = r_q.m.three ? mosi_i : miso;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (start) begin
                r_d.st       = ST_PREP;
                r_d.m        = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb: cfg_lsb_first,
                                 cs_high: cfg_cs_high, three: cfg_three_wire,
                                 turn: cfg_turn_pulse, rxdir: cfg_rx_dir};
                r_d.len_m1   = cfg_len_m1;
                r_d.div      = cfg_half_div;
                r_d.idx      = cfg_cs_idx;
                r_d.tx_sh    = tx_load;
                r_d.rx_sh    = '0;
                r_d.edge_cnt = '0;
                r_d.sck      = cfg_cpol;
            end
            ST_PREP: if (tick) begin
                r_d.pol[r_q.idx] = r_q.m.cs_high;
                r_d.hiz          = r_q.m.three && r_q.m.rxdir;
                r_d.st           = ST_ARM;
            end
            ST_ARM: if (tick) begin
                r_d.sel = 1'b1;
                r_d.st  = ST_LEAD;
            end
            ST_LEAD: if (tick) begin
                r_d.st = (r_q.m.three && r_q.m.rxdir && r_q.m.turn) ? ST_TURN_A : ST_SHIFT;
            end
            ST_TURN_A: if (tick) begin
                r_d.sck = ~r_q.m.cpol;
                r_d.st  = ST_TURN_B;
            end
            ST_TURN_B: if (tick) begin
                r_d.sck = r_q.m.cpol;
                r_d.st  = ST_SHIFT;
            end
            ST_SHIFT: if (tick) begin
                r_d.sck = ~r_q.sck;
                if (sample_now) r_d.rx_sh = {r_q.rx_sh[WORD_W-2:0], din};
                if (launch_now) r_d.tx_sh = r_q.tx_sh << 1;
                r_d.edge_cnt = r_q.edge_cnt + EDGE_W'(1);
                if (last_edge) r_d.st = ST_TAIL;
            end
            ST_TAIL: if (tick) begin
                r_d.sel     = 1'b0;
                r_d.hiz     = 1'b0;
                r_d.tx_sh   = '0;
                r_d.done    = 1'b1;
                r_d.rx_word = rx_fin;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rx_word = r_q.rx_word;
    assign sck     = r_q.sck;
    assign mosi_o  = r_q.tx_sh[WORD_W-1];
    assign mosi_oe = !cfg_tx_absent && !r_q.hiz;

    // R12: completion pulse lines up with the idle state and lasts one cycle
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: SCK already at its idle level when a line becomes selected
    a_r4_sck_parked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sel) |-> (sck == r_q.m.cpol) && $stable(sck));
    // R1: SCK moves only on divider ticks while a transfer runs
    a_r1_sck_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sck));
    // R5: at most one line away from its resting level
    a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_o ^ ~r_q.pol) <= 1);
    // R8: pad released only for a three-wire receive word
    a_r8_hiz_scope: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hiz |-> (r_q.m.three && r_q.m.rxdir && busy));
    // R11: captured settings stay fixed while busy
    a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.m) && $stable(r_q.len_m1) && $stable(r_q.idx));
endmodule

// File: tb/spiw_master_tb.sv
`timescale 1ns/1ps
module spiw_master_tb;
    localparam int W   = 32;
    localparam int NCS = 4;
    localparam int DW  = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic c_cpol = 0, c_cpha = 0, c_lsb = 0, c_csh = 0, c_three = 0, c_turn = 0;
    logic c_rxdir = 0, c_txabs = 0;
    logic [4:0]    c_len_m1 = '0;
    logic [DW-1:0] c_div = '0;
    logic [1:0]    c_idx = '0;
    logic [W-1:0]  c_tx = '0;
    logic busy, done, sck, mosi_o, mosi_oe, mosi_pad, miso_w;
    logic [W-1:0]   rx_word;
    logic [NCS-1:0] cs_o;

    // behavioural target state
    logic [W-1:0]   s_word, s_rx;
    int             s_len, s_idx, s_skip, s_edges, s_outidx, s_rxidx;
    logic           s_cpol, s_cpha, s_lsb, s_act, s_three, s_bit, s_sel, in_xfer;
    logic           sck_ok_at_sel, oe_at_sample;
    logic [NCS-1:0] cs_at_sel;
    int             cyc, last_cyc, min_gap;
    logic [NCS-1:0] exp_pol;
    int checks, errors;

    assign mosi_pad = mosi_oe ? mosi_o : s_bit;
    assign miso_w   = s_three ? ~s_bit : s_bit;

    spiw_master #(.WORD_W(W), .NUM_CS(NCS), .DIV_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_cpol(c_cpol), .cfg_cpha(c_cpha), .cfg_lsb_first(c_lsb),
        .cfg_cs_high(c_csh), .cfg_three_wire(c_three), .cfg_turn_pulse(c_turn),
        .cfg_rx_dir(c_rxdir), .cfg_tx_absent(c_txabs), .cfg_len_m1(c_len_m1),
        .cfg_half_div(c_div), .cfg_cs_idx(c_idx), .tx_word(c_tx),
        .busy(busy), .done(done), .rx_word(rx_word), .sck(sck),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_pad), .miso(miso_w),
        .cs_o(cs_o)
    );

    function automatic logic bit_of(input logic [W-1:0] w, input int len,
                                    input logic lsb, input int k);
        if (k >= len) return 1'b0;
        return lsb ? w[k] : w[len-1-k];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // target: select detection
    always @(cs_o) begin
        if (in_xfer && !s_sel && cs_o[s_idx] == s_act) begin
            s_sel         = 1'b1;
            sck_ok_at_sel = (sck == s_cpol);
            cs_at_sel     = cs_o;
            s_outidx      = 0;
            if (!s_cpha) begin
                s_bit    = bit_of(s_word, s_len, s_lsb, 0);
                s_outidx = 1;
            end
        end else if (s_sel && cs_o[s_idx] != s_act) begin
            s_sel = 1'b0;
        end
    end

    // target: clock edges
    always @(sck) begin
        if (s_sel) begin
            if (s_edges > 0 && (cyc - last_cyc) < min_gap) min_gap = cyc - last_cyc;
            last_cyc = cyc;
            s_edges++;
            if (s_edges > s_skip) begin
                if (s_cpha ? (sck == s_cpol) : (sck != s_cpol)) begin
                    if (s_rxidx < s_len)
                        s_rx[s_lsb ? s_rxidx : s_len-1-s_rxidx] = mosi_pad;
                    if (mosi_oe) oe_at_sample = 1'b1;
                    s_rxidx++;
                end else begin
                    s_bit = bit_of(s_word, s_len, s_lsb, s_outidx);
                    s_outidx++;
                end
            end
        end
    end

    task automatic run_xfer(input logic cpol, cpha, lsb, csh, three, turn, rxdir, txabs,
                            input int len, input int div, input int idx,
                            input logic [W-1:0] tx, input logic [W-1:0] sw,
                            input string rx_req, input bit mid_start);
        logic [W-1:0]   mask, exp_rx;
        logic [NCS-1:0] exp_sel;
        int             exp_edges, waited;
        bit             oe_low, oe_high, got;
        mask      = (len == 32) ? '1 : ((W'(1) << len) - 1);
        exp_rx    = (three && !rxdir) ? (tx & mask) : (sw & mask);
        exp_edges = 2*len + ((three && rxdir && turn) ? 2 : 0);
        exp_pol[idx] = csh;
        exp_sel      = ~exp_pol;
        exp_sel[idx] = csh;

        @(negedge clk);
        c_cpol = cpol; c_cpha = cpha; c_lsb = lsb; c_csh = csh; c_three = three;
        c_turn = turn; c_rxdir = rxdir; c_txabs = txabs;
        c_len_m1 = 5'(len-1); c_div = DW'(div); c_idx = 2'(idx); c_tx = tx;
        s_word = sw; s_rx = '0; s_len = len; s_idx = idx; s_cpol = cpol; s_cpha = cpha;
        s_lsb = lsb; s_act = csh; s_three = three; s_skip = (three && rxdir && turn) ? 2 : 0;
        s_edges = 0; s_rxidx = 0; s_outidx = 0; s_sel = 0; sck_ok_at_sel = 0;
        oe_at_sample = 0; min_gap = 1 << 30; in_xfer = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        oe_low = 0; oe_high = 0; got = 0; waited = 0;
        while (!got && waited < 40000) begin
            if (mosi_oe) oe_high = 1; else oe_low = 1;
            if (mid_start && waited == 6) begin
                start = 1'b1; c_tx = ~tx; c_len_m1 = 5'(len-2);
            end else begin
                start = 1'b0;
            end
            if (done) got = 1;
            else begin
                @(negedge clk);
                waited++;
            end
        end
        start = 1'b0;
        chk(got, "R12", "done seen", got, 1);
        chk(!busy, "R12", "busy low with done", busy, 0);
        chk(rx_word == exp_rx, rx_req, "received word", rx_word, exp_rx);
        @(negedge clk);
        chk(!done, "R12", "done single cycle", done, 0);
        in_xfer = 0;
        chk(s_edges == exp_edges, three && rxdir && turn ? "R9" : "R2",
            "SCK edge count", s_edges, exp_edges);
        chk(sck == cpol, "R2", "SCK idle level", sck, cpol);
        chk(sck_ok_at_sel, "R4", "SCK parked before select", sck_ok_at_sel, 1);
        chk(cs_at_sel == exp_sel, "R5", "lines at select", cs_at_sel, exp_sel);
        chk(cs_o == ~exp_pol, "R5", "lines at rest", cs_o, ~exp_pol);
        chk(min_gap == div + 1, "R1", "edge spacing", min_gap, div + 1);
        if (!(three && rxdir) && !txabs)
            chk(s_rx == (tx & mask), "R3", "word seen by target", s_rx, tx & mask);
        if (txabs)
            chk(!oe_high, "R10", "MOSI never driven", oe_high, 0);
        else if (three && rxdir)
            chk(!oe_at_sample, "R8", "pad released on data edges", oe_at_sample, 0);
        else
            chk(!oe_low, "R8", "MOSI kept driven", oe_low, 0);
        if (mid_start) begin
            bit again;
            again = 0;
            repeat (30) begin
                @(negedge clk);
                if (busy) again = 1;
            end
            chk(!again, "R11", "no second transfer", again, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_o == 4'hF, "R6", "reset lines", cs_o, 4'hF);
        chk(sck == 1'b0, "R6", "reset SCK", sck, 0);
        chk(!busy && !done, "R6", "reset busy/done", {busy, done}, 0);
        chk(rx_word == '0, "R6", "reset rx_word", rx_word, 0);
        chk(mosi_oe, "R6", "reset MOSI driven", mosi_oe, 1);
    endtask

    task automatic t_mode0_msb();
        run_xfer(0,0,0,0, 0,0,0,0, 8, 1, 0, 32'hA5, 32'h3C, "R2", 0);
    endtask
    task automatic t_mode3_lsb_fast();
        run_xfer(1,1,1,0, 0,0,0,0, 12, 0, 1, 32'h5A3, 32'hC61, "R3", 0);
    endtask
    task automatic t_mode1_full_word();
        run_xfer(0,1,0,0, 0,0,0,0, 32, 2, 3, 32'hDEADBEEF, 32'h12345678, "R3", 0);
    endtask
    task automatic t_mode2_one_bit();
        run_xfer(1,0,1,0, 0,0,0,0, 1, 3, 2, 32'h0, 32'h1, "R3", 0);
    endtask
    task automatic t_cs_polarity();
        run_xfer(0,0,0,1, 0,0,0,0, 8, 1, 2, 32'h81, 32'h7E, "R5", 0);
        run_xfer(0,0,0,0, 0,0,0,0, 8, 1, 0, 32'h42, 32'hC3, "R5", 0);
        run_xfer(1,1,0,0, 0,0,0,0, 6, 0, 2, 32'h2D, 32'h15, "R5", 0);
    endtask
    task automatic t_three_rx_turn();
        run_xfer(1,0,0,0, 1,1,1,0, 10, 1, 1, 32'h0, 32'h2B7, "R7", 0);
    endtask
    task automatic t_three_rx_plain();
        run_xfer(0,1,1,0, 1,0,1,0, 7, 0, 3, 32'h0, 32'h4D, "R7", 0);
    endtask
    task automatic t_three_tx_loopback();
        run_xfer(0,0,0,0, 1,1,0,0, 9, 1, 0, 32'h1A5, 32'h0, "R7", 0);
    endtask
    task automatic t_four_wire_rx_dir();
        run_xfer(1,1,0,0, 0,0,1,0, 16, 1, 1, 32'hFFFF, 32'hBEEF, "R8", 0);
    endtask
    task automatic t_tx_absent();
        run_xfer(0,0,1,0, 1,1,1,1, 8, 2, 0, 32'hFF, 32'h96, "R10", 0);
        c_txabs = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mosi_oe, "R10", "MOSI off while idle", mosi_oe, 0);
        c_txabs = 1'b0;
    endtask
    task automatic t_start_while_busy();
        run_xfer(0,0,0,0, 0,0,0,0, 8, 2, 1, 32'h5C, 32'hA3, "R11", 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        checks = 0; errors = 0; cyc = 0; in_xfer = 0; s_sel = 0; s_bit = 0;
        s_three = 0; exp_pol = '0; s_idx = 0; s_act = 0;
        t_reset();
        t_mode0_msb();
        t_mode3_lsb_fast();
        t_mode1_full_word();
        t_mode2_one_bit();
        t_cs_polarity();
        t_three_rx_turn();
        t_three_rx_plain();
        t_three_tx_loopback();
        t_four_wire_rx_dir();
        t_tx_absent();
        t_start_while_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule